// File: doc/BRIEF.md
# Masked Bit-Manipulation Unit

This block transforms one operand word through a small family of trailing-bit operations, such as isolating the lowest set bit, smearing trailing zeros or clearing trailing ones. The transform is confined to the bit positions selected by a mask. A 5-bit mode word sets three things: whether the first term is the masked operand or its inverse, which arithmetic variant of the masked operand is the second term (negate, decrement, increment or inverted increment), and the bitwise operator that merges the two terms.

The mask comes either from a mask word or, when the mask source is flagged as the zero register, is all ones. Result bits outside the mask are normally cleared. A restore flag can instead copy the operand's own bits into those positions. The datapath is combinational. A single output register, cleared by a synchronous active-low reset, presents the result one clock after the inputs.

Top module: `bmx_unit`

## Requirements
- R1: When `mask_sel_zero` is 1 the effective mask is all ones and `mask_word` has no effect. When it is 0 the effective mask equals `mask_word`.
- R2: The working value W is `operand & mask`. The first term is W when `mode[0]` is 1 and ~W when `mode[0]` is 0.
- R3: `mode[2:1]` selects the second term: 00 gives -W, 01 gives W-1, 10 gives W+1 and 11 gives ~(W+1).
- R4: Both terms are ANDed with the mask. `mode[4:3]` selects how they are merged: 00 is OR, 01 is AND and 10 is XOR.
- R5: When `mode[4:3]` is 11 the merged value is all zeros.
- R6: When `keep_outside` is 0, every result bit outside the effective mask is 0.
- R7: When `keep_outside` is 1, every result bit outside the effective mask equals the operand bit in the same position. Bits inside the mask are unchanged by this flag.
- R8: `result` is registered. It reflects the inputs sampled at the previous rising edge. A clock edge with `rst_n` low sets it to 0.
- R9: All arithmetic on W wraps modulo 2^XLEN. For example, an all-ones W incremented gives 0, and zero decremented gives all ones.
- R10: Mode 5'b01001 (AND, negate, first term W), with an all-ones mask, yields the lowest set bit of the operand, so at most one result bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| operand | input | XLEN | Source operand |
| mask_word | input | XLEN | Mask value when the mask source is not the zero register |
| mask_sel_zero | input | 1 | 1 selects an all-ones mask |
| mode | input | 5 | [4:3] merge operator, [2:1] second-term variant, [0] first-term polarity |
| keep_outside | input | 1 | 1 copies operand bits outside the mask into the result |
| result | output | XLEN | Registered result |

## Verification
Each result is due exactly one rising edge after its inputs are applied. This includes the zero produced by a reset edge. The driver applies inputs on the falling edge and queues the expected word. The monitor wakes a quarter period after the next rising edge and compares exactly one queued item. No check therefore samples a value that is still being set up or already replaced. All 32 mode codes are swept with the restore flag on and off, over zero, all-ones and random operands and masks. Directed cases cover wraparound and lowest-set-bit isolation.

// File: rtl/bmx_pkg.sv
// Shared encodings for the masked bit-manipulation unit.
// Assumes the mode word is split as [4:3] merge, [2:1] second term, [0] polarity.
package bmx_pkg;
    localparam int MODE_W = 5;

    typedef enum logic [1:0] {
        MERGE_OR   = 2'b00,
        MERGE_AND  = 2'b01,
        MERGE_XOR  = 2'b10,
        MERGE_NONE = 2'b11
    } merge_e;

    typedef enum logic [1:0] {
        SEC_NEG  = 2'b00,
        SEC_DEC  = 2'b01,
        SEC_INC  = 2'b10,
        SEC_NINC = 2'b11
    } second_e;
endpackage

// File: rtl/bmx_terms.sv
// Builds the two masked terms from the working value.
// Assumes 'work' is already the operand ANDed with the mask.
// Arithmetic wraps modulo 2^XLEN.
module bmx_terms
    import bmx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] work,
    input  logic [XLEN-1:0] eff_mask,
    input  logic            keep_work,
    input  second_e         sec_sel,
    output logic [XLEN-1:0] term_a,
    output logic [XLEN-1:0] term_b
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] inc_val;
    logic [XLEN-1:0] raw_b;

    // First term: working value or its inverse, then masked.
    always_comb begin
        term_a = (keep_work ? work : ~work) & eff_mask;
    end

    // Second term: one of four wrapping arithmetic variants, then masked.
    always_comb begin
        inc_val = work + ONE;
        unique case (sec_sel)
            SEC_NEG:  raw_b = ~work + ONE;
            SEC_DEC:  raw_b = work - ONE;
            SEC_INC:  raw_b = inc_val;
            default:  raw_b = ~inc_val;
        endcase
        term_b = raw_b & eff_mask;
    end
endmodule

// File: rtl/bmx_merge.sv
// Merges two terms with a selectable bitwise operator.
// Assumes the unused operator code must give zeros.
module bmx_merge
    import bmx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] term_a,
    input  logic [XLEN-1:0] term_b,
    input  merge_e          merge_sel,
    output logic [XLEN-1:0] merged
);
    // Operator select; the spare code yields a deterministic zero.
    always_comb begin
        unique case (merge_sel)
            MERGE_OR:  merged = term_a | term_b;
            MERGE_AND: merged = term_a & term_b;
            MERGE_XOR: merged = term_a ^ term_b;
            default:   merged = '0;
        endcase
    end
endmodule

// File: rtl/bmx_unit.sv
// Top of the masked bit-manipulation unit.
// It forms the mask, runs the term and merge stages, then re-masks the
// merged value and optionally restores the outside bits. The result is
// registered once. Assumes inputs are held stable from one falling edge
// to the next rising edge.
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     operand,
    input  logic [XLEN-1:0]     mask_word,
    input  logic                mask_sel_zero,
    input  logic [MODE_W-1:0]   mode,
    input  logic                keep_outside,
    output logic [XLEN-1:0]     result
);
    logic [XLEN-1:0] eff_mask;
    logic [XLEN-1:0] work;
    logic [XLEN-1:0] term_a;
    logic [XLEN-1:0] term_b;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] outside;
    logic [XLEN-1:0] next_result;
    merge_e          merge_sel;
    second_e         sec_sel;

    // Mask source and working value.
    always_comb begin
        eff_mask = mask_sel_zero ? '1 : mask_word;
        work     = operand & eff_mask;
    end

    // Mode field split into its three controls.
    always_comb begin
        merge_sel = merge_e'(mode[4:3]);
        sec_sel   = second_e'(mode[2:1]);
    end

    bmx_terms #(.XLEN(XLEN)) u_terms (
        .work      (work),
        .eff_mask  (eff_mask),
        .keep_work (mode[0]),
        .sec_sel   (sec_sel),
        .term_a    (term_a),
        .term_b    (term_b)
    );

    bmx_merge #(.XLEN(XLEN)) u_merge (
        .term_a    (term_a),
        .term_b    (term_b),
        .merge_sel (merge_sel),
        .merged    (merged)
    );

    // Final mask and optional restore of the outside bits.
    always_comb begin
        outside     = keep_outside ? (operand & ~eff_mask) : '0;
        next_result = (merged & eff_mask) | outside;
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= next_result;
    end
endmodule

// File: rtl/bmx_unit_chk.sv
// Port-level properties of bmx_unit, attached with bind.
// Assumes one cycle of latency from inputs to result.
module bmx_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] operand,
    input logic [XLEN-1:0] mask_word,
    input logic            mask_sel_zero,
    input logic [4:0]      mode,
    input logic            keep_outside,
    input logic [XLEN-1:0] result
);
    // Reset edge leaves the result at zero.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> result == '0);

    // Without restore, bits outside the given mask are zero.
    assert_outside_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep_outside && !mask_sel_zero) |=> ((result & ~$past(mask_word)) == '0));

    // With restore, outside bits follow the operand.
    assert_outside_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_outside && !mask_sel_zero) |=>
            ((result & ~$past(mask_word)) == ($past(operand) & ~$past(mask_word))));

    // Spare merge code gives zero when nothing is restored.
    assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[4:3] == 2'b11 && !keep_outside) |=> result == '0);

    // Lowest-set-bit mode leaves at most one bit set.
    assert_lowest_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b01001 && mask_sel_zero) |=> $onehot0(result));
endmodule

bind bmx_unit bmx_unit_chk #(.XLEN(XLEN)) u_bmx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .operand       (operand),
    .mask_word     (mask_word),
    .mask_sel_zero (mask_sel_zero),
    .mode          (mode),
    .keep_outside  (keep_outside),
    .result        (result)
);

// File: tb/test_bmx_unit.sv
// Scoreboard bench for bmx_unit.
module test_bmx_unit;
    localparam int XLEN = 64;
    typedef logic [XLEN-1:0] word_t;
    typedef struct {
        word_t exp;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    word_t       operand = '0;
    word_t       mask_word = '0;
    logic        mask_sel_zero = 1'b0;
    logic [4:0]  mode = '0;
    logic        keep_outside = 1'b0;
    word_t       result;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bmx_unit #(.XLEN(XLEN)) i_bmx_unit (
        .clk(clk), .rst_n(rst_n), .operand(operand), .mask_word(mask_word),
        .mask_sel_zero(mask_sel_zero), .mode(mode), .keep_outside(keep_outside),
        .result(result)
    );

    // Reference model written from the requirement text.
    function automatic word_t model(word_t op, word_t mw, bit mz, logic [4:0] md, bit kp);
        word_t m, w, f, s, c;
        m = mz ? {XLEN{1'b1}} : mw;
        w = op & m;
        f = md[0] ? w : ~w;
        case (md[2:1])
            2'b00: s = 0 - w;
            2'b01: s = w - 1;
            2'b10: s = w + 1;
            default: s = ~(w + 1);
        endcase
        f = f & m;
        s = s & m;
        case (md[4:3])
            2'b00: c = f | s;
            2'b01: c = f & s;
            2'b10: c = f ^ s;
            default: c = '0;
        endcase
        c = c & m;
        if (kp) c = c | (op & ~m);
        return c;
    endfunction

    function automatic word_t rnd();
        return {$urandom(), $urandom()};
    endfunction

    // Driver: apply one stimulus on a falling edge and queue its expectation.
    task automatic drive(word_t op, word_t mw, bit mz, logic [4:0] md, bit kp, string tag);
        item_t it;
        @(negedge clk);
        operand = op; mask_word = mw; mask_sel_zero = mz; mode = md; keep_outside = kp;
        it.exp = rst_n ? model(op, mw, mz, md, kp) : '0;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare one queued item a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (result !== it.exp) begin
                n_bad++;
                $display("FAIL %s: result=%h expected=%h", it.tag, result, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #3000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        word_t ops[5];
        word_t msk[5];
        // R8: reset clears result even with active inputs.
        drive({XLEN{1'b1}}, {XLEN{1'b1}}, 1'b1, 5'b00000, 1'b1, "R8 reset");
        drive(64'h1234, '0, 1'b0, 5'b00010, 1'b1, "R8 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // Main sweep: every mode, restore on and off, several patterns.
        ops[0] = '0;          msk[0] = {XLEN{1'b1}};
        ops[1] = {XLEN{1'b1}}; msk[1] = '0;
        ops[2] = rnd();       msk[2] = rnd();
        ops[3] = rnd();       msk[3] = 64'h00FF_F0F0_0FF0_FF00;
        ops[4] = rnd();       msk[4] = rnd();
        for (int p = 0; p < 5; p++) begin
            for (int md = 0; md < 32; md++) begin
                for (int kp = 0; kp < 2; kp++) begin
                    string tg;
                    bit mz;
                    mz = (p == 4);
                    tg = (md[4:3] == 2'b11) ? "R5" : "R2 R3 R4";
                    tg = {tg, kp ? " R7" : " R6", mz ? " R1" : ""};
                    drive(ops[p], msk[p], mz, 5'(md), kp[0], tg);
                end
            end
        end
        // R1: mask word ignored when zero-register flag is set.
        drive(64'hF0F0_0000_1234_5678, 64'h0000_0000_0000_000F, 1'b1, 5'b10001, 1'b0, "R1 mask ignored");
        // R9: wraparound of increment and decrement.
        drive({XLEN{1'b1}}, '0, 1'b1, 5'b10101, 1'b0, "R9 inc wrap");
        drive('0, '0, 1'b1, 5'b10011, 1'b0, "R9 dec wrap");
        // R10: lowest set bit isolation.
        drive(64'h0000_0000_0000_0058, '0, 1'b1, 5'b01001, 1'b0, "R10 lowest bit");
        drive(64'h8000_0000_0000_0000, '0, 1'b1, 5'b01001, 1'b0, "R10 lowest bit");
        // R7: restore with inside-mask bits produced by the transform.
        drive(64'hAAAA_5555_AAAA_5555, 64'h0000_FFFF_0000_FFFF, 1'b0, 5'b00100, 1'b1, "R7 restore");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule